// File: doc/BRIEF.md
# Receive Page Ring Write Controller

This block decides where each byte of an incoming frame lands in a receive ring made of fixed-size pages in buffer memory. The ring occupies the pages from a start page up to, but not including, a stop page. A current-page register plays the role of the write pointer; a boundary page supplied from outside plays the role of the read pointer, marking the oldest page the host has not yet consumed.

For every frame the controller begins writing at the current page, leaving the first four bytes of that page free. As bytes arrive it produces one memory write per byte and moves on to the following page when one fills, wrapping from the stop page back to the start page. Before it enters a new page it compares that page with the boundary, and it abandons the frame rather than overwrite unread data. When the frame ends it does one of two things. For an accepted frame it fills the four reserved bytes with a small header and moves the current page past the frame. For a rejected frame it leaves the current page untouched, so every page the frame used is reclaimed.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset the current page reads 0, and no write or abort pulse is produced. A pulse on `curr_init_i` while idle loads the current page from `pstart_i`.
- R2: The first data byte of a frame is written to offset 4 of the current page, and later bytes, including the trailing CRC bytes, go to consecutive offsets. Each write appears on the write port one clock after the byte is presented. The address is the page number concatenated above the in-page offset.
- R3: When a page is full, the next byte goes to offset 0 of the following page. If the following page number equals `pstop_i`, the next byte goes to offset 0 of page `pstart_i` instead.
- R4: If a byte would be written into a new page whose number equals `bndry_i`, that byte is not written. `abort_o` pulses for one clock, one clock later. The frame produces no further writes and no header, and the current page keeps its value.
- R5: For an accepted frame, four header writes follow the end-of-frame pulse, to offsets 0, 1, 2 and 3 of the frame's first page. In order they carry the status byte, the next-frame page, the low byte of the received byte count and the high byte of that count. The count is the number of frame bytes written.
- R6: After an accepted frame the current page becomes the page following the last page the frame used, wrapping at `pstop_i`, and the rest of the last page is left unused. A frame that exactly fills its last page still advances by one page.
- R7: A frame ended with `frm_good_i` low while `accept_err_i` is low gets no header, and the current page keeps its value.
- R8: A frame ended with `frm_good_i` low while `accept_err_i` is high is handled like a good frame: it gets a header and the current page advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pstart_i | input | PAGE_W | First page of the ring |
| pstop_i | input | PAGE_W | Page one past the last page of the ring |
| bndry_i | input | PAGE_W | Oldest page not yet read by the host |
| accept_err_i | input | 1 | Keep frames ended as bad |
| curr_init_i | input | 1 | Load current page from pstart_i (idle only) |
| frm_start_i | input | 1 | Start of a frame |
| byte_vld_i | input | 1 | A frame byte is present on byte_i |
| byte_i | input | 8 | Frame byte |
| frm_end_i | input | 1 | End of frame, qualifies frm_good_i and rx_stat_i |
| frm_good_i | input | 1 | Frame free of runt, CRC and alignment errors |
| rx_stat_i | input | 8 | Status byte for the header |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | PAGE_W+OFFS_W | Memory byte address |
| wr_data_o | output | 8 | Memory write data |
| abort_o | output | 1 | One-clock pulse on a boundary abort |
| curr_page_o | output | PAGE_W | Current page (write pointer) |

## Verification
The bench builds the block with PAGE_W = 8 and OFFS_W = 4, which gives 16-byte pages with 12 data bytes after the header. Frames of a few dozen bytes therefore cross page edges, wrap from the stop page to the start page, hit the boundary and exactly fill a page. The ring spans pages 2 to 5, so wrap-around of both the data and the next-frame pointer occurs within a handful of frames.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int unsigned HDR_BYTES = 4;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RECV,
    S_DROP,
    S_HDR
  } rxr_state_e;
endpackage

// File: rtl/rxr_page_step.sv
// Next page in the ring, with wrap at the stop page and boundary compare.
module rxr_page_step #(
  parameter int unsigned PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] cur_pg_i,
  input  logic [PAGE_W-1:0] pstart_i,
  input  logic [PAGE_W-1:0] pstop_i,
  input  logic [PAGE_W-1:0] bndry_i,
  output logic [PAGE_W-1:0] nxt_pg_o,
  output logic              hit_bndry_o
);
  logic [PAGE_W-1:0] inc_pg;

  always_comb begin
    inc_pg      = cur_pg_i + 1'b1;
    nxt_pg_o    = (inc_pg == pstop_i) ? pstart_i : inc_pg;
    hit_bndry_o = (nxt_pg_o == bndry_i);
  end
endmodule

// File: rtl/rxr_wptr.sv
// Frame write pointer: page, in-page offset, pending link, byte count.
module rxr_wptr
  import rxr_pkg::*;
#(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFFS_W = 8,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned ADDR_W = PAGE_W + OFFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] start_pg_i,
  input  logic              byte_i,
  input  logic [PAGE_W-1:0] nxt_pg_i,
  output logic [PAGE_W-1:0] wpage_o,
  output logic              need_link_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [OFFS_W-1:0] OFFS_MAX = '1;
  localparam logic [OFFS_W-1:0] OFFS_HDR = OFFS_W'(HDR_BYTES);

  logic [PAGE_W-1:0] wpage_q;
  logic [OFFS_W-1:0] woff_q;
  logic              link_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wpage_q <= '0;
      woff_q  <= '0;
      link_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (start_i) begin
      wpage_q <= start_pg_i;
      woff_q  <= OFFS_HDR;
      link_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (byte_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (link_q) begin
        wpage_q <= nxt_pg_i;
        woff_q  <= OFFS_W'(1);
        link_q  <= 1'b0;
      end else begin
        woff_q <= woff_q + 1'b1;
        link_q <= (woff_q == OFFS_MAX);
      end
    end
  end

  assign wpage_o     = wpage_q;
  assign need_link_o = link_q;
  assign cnt_o       = cnt_q;
  assign addr_o      = link_q ? {nxt_pg_i, {OFFS_W{1'b0}}} : {wpage_q, woff_q};

  AST_HDR_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (woff_q == OFFS_HDR && !link_q)); // R2
  AST_LINK_OFFS0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_i && link_q && !start_i) |=> (woff_q == OFFS_W'(1) && wpage_q == $past(nxt_pg_i))); // R3
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
  import rxr_pkg::*;
#(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFFS_W = 8,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned ADDR_W = PAGE_W + OFFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PAGE_W-1:0] pstart_i,
  input  logic [PAGE_W-1:0] pstop_i,
  input  logic [PAGE_W-1:0] bndry_i,
  input  logic              accept_err_i,
  input  logic              curr_init_i,
  input  logic              frm_start_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              frm_end_i,
  input  logic              frm_good_i,
  input  logic [7:0]        rx_stat_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              abort_o,
  output logic [PAGE_W-1:0] curr_page_o
);
  localparam int unsigned HIDX_W = $clog2(HDR_BYTES);
  localparam logic [HIDX_W-1:0] HIDX_LAST = HIDX_W'(HDR_BYTES - 1);

  rxr_state_e        state_q;
  logic [PAGE_W-1:0] curr_q;
  logic [PAGE_W-1:0] nxt_hold_q;   // scratch: next-frame page
  logic [7:0]        stat_q;
  logic [HIDX_W-1:0] hidx_q;

  logic [PAGE_W-1:0] wpage;
  logic [PAGE_W-1:0] nxt_pg;
  logic              hit_bndry;
  logic              need_link;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] data_addr;

  logic start_go, byte_go, abort_now, accept;
  logic [7:0] hdr_byte;

  rxr_page_step #(.PAGE_W(PAGE_W)) u_step (
    .cur_pg_i   (wpage),
    .pstart_i   (pstart_i),
    .pstop_i    (pstop_i),
    .bndry_i    (bndry_i),
    .nxt_pg_o   (nxt_pg),
    .hit_bndry_o(hit_bndry)
  );

  rxr_wptr #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W), .CNT_W(CNT_W)) u_wptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_go),
    .start_pg_i (curr_q),
    .byte_i     (byte_go),
    .nxt_pg_i   (nxt_pg),
    .wpage_o    (wpage),
    .need_link_o(need_link),
    .cnt_o      (cnt),
    .addr_o     (data_addr)
  );

  always_comb begin
    start_go  = (state_q == S_IDLE) && frm_start_i;
    abort_now = (state_q == S_RECV) && !frm_end_i && byte_vld_i && need_link && hit_bndry;
    byte_go   = (state_q == S_RECV) && !frm_end_i && byte_vld_i && !(need_link && hit_bndry);
    accept    = frm_good_i || accept_err_i;
    case (hidx_q)
      2'd0:    hdr_byte = stat_q;
      2'd1:    hdr_byte = 8'(nxt_hold_q);
      2'd2:    hdr_byte = cnt[7:0];
      default: hdr_byte = 8'(cnt >> 8);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      curr_q     <= '0;
      nxt_hold_q <= '0;
      stat_q     <= '0;
      hidx_q     <= '0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      abort_o    <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      abort_o <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (curr_init_i) curr_q <= pstart_i;
          if (frm_start_i) state_q <= S_RECV;
        end
        S_RECV: begin
          if (frm_end_i) begin
            if (accept) begin
              state_q    <= S_HDR;
              hidx_q     <= '0;
              nxt_hold_q <= nxt_pg;
              stat_q     <= rx_stat_i;
            end else begin
              state_q <= S_IDLE;  // rollback: curr_q untouched
            end
          end else if (abort_now) begin
            abort_o <= 1'b1;
            state_q <= S_DROP;
          end else if (byte_go) begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= data_addr;
            wr_data_o <= byte_i;
          end
        end
        S_DROP: begin
          if (frm_end_i) state_q <= S_IDLE;
        end
        default: begin  // S_HDR
          wr_en_o   <= 1'b1;
          wr_addr_o <= {curr_q, OFFS_W'(hidx_q)};
          wr_data_o <= hdr_byte;
          hidx_q    <= hidx_q + 1'b1;
          if (hidx_q == HIDX_LAST) begin
            state_q <= S_IDLE;
            curr_q  <= nxt_hold_q;
          end
        end
      endcase
    end
  end

  assign curr_page_o = curr_q;

  AST_ABORT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !wr_en_o); // R4
  AST_ABORT_KEEPS_CURR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $stable(curr_q)); // R4
  AST_WR_IN_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o[ADDR_W-1:OFFS_W] >= pstart_i && wr_addr_o[ADDR_W-1:OFFS_W] < pstop_i)); // R3
  AST_REJECT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RECV && frm_end_i && !accept) |=> ($stable(curr_q) && !wr_en_o)); // R7
  AST_HDR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HDR && hidx_q == '0) |=> (wr_en_o && wr_addr_o[OFFS_W-1:0] == '0)); // R5
  AST_CURR_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HDR && hidx_q == HIDX_LAST) |=> (curr_q == $past(nxt_hold_q))); // R6
endmodule

// File: tb/sim_rx_ring_mgr.sv
module sim_rx_ring_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE_W = 8;
  localparam int OFFS_W = 4;
  localparam int ADDR_W = PAGE_W + OFFS_W;
  localparam int PAGE_BYTES = 1 << OFFS_W;

  typedef struct {
    bit                is_abort;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        data;
    string             req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PAGE_W-1:0] pstart = 8'd2, pstop = 8'd6, bndry = 8'd1;
  logic accept_err = 1'b0, curr_init = 1'b0, frm_start = 1'b0, byte_vld = 1'b0;
  logic [7:0] byte_d = '0, rx_stat = '0;
  logic frm_end = 1'b0, frm_good = 1'b0;
  logic wr_en, abort;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0] wr_data;
  logic [PAGE_W-1:0] curr_page;

  int n_vec = 0, n_bad = 0;
  exp_t q[$];
  logic [PAGE_W-1:0] ecurr;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_mgr #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W), .CNT_W(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pstart_i(pstart), .pstop_i(pstop), .bndry_i(bndry),
    .accept_err_i(accept_err), .curr_init_i(curr_init), .frm_start_i(frm_start),
    .byte_vld_i(byte_vld), .byte_i(byte_d), .frm_end_i(frm_end), .frm_good_i(frm_good),
    .rx_stat_i(rx_stat), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .abort_o(abort), .curr_page_o(curr_page)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [PAGE_W-1:0] step_pg(input logic [PAGE_W-1:0] p);
    return (p + 8'd1 == pstop) ? pstart : p + 8'd1;
  endfunction

  // Monitor: pops expected items as the design emits writes and aborts.
  always @(negedge clk) begin
    if (rst_n && (wr_en || abort)) begin
      if (q.size() == 0) begin
        chk("R2 unexpected output", {wr_en, abort}, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.is_abort) begin
          chk(e.req, {wr_en, abort}, 32'b01);
        end else begin
          chk(e.req, {wr_en, abort}, 32'b10);
          chk(e.req, 32'(wr_addr), 32'(e.addr));
          chk(e.req, 32'(wr_data), 32'(e.data));
        end
      end
    end
  end

  // Driver: models the ring, queues expected writes, drives one frame.
  task automatic send_frame(input int n, input bit good, input logic [7:0] st,
                            input logic [7:0] seed, input string creq);
    logic [PAGE_W-1:0] pg, first;
    int off, cnt;
    bit aborted;
    exp_t e;
    pg = ecurr; first = ecurr; off = 4; cnt = 0; aborted = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (!aborted) begin
        if (off == PAGE_BYTES) begin
          if (step_pg(pg) == bndry) begin
            aborted = 1'b1;
            e.is_abort = 1'b1; e.addr = '0; e.data = '0; e.req = "R4";
            q.push_back(e);
          end else begin
            pg = step_pg(pg); off = 0;
          end
        end
        if (!aborted) begin
          e.is_abort = 1'b0; e.addr = {pg, 4'(off)}; e.data = seed + 8'(i);
          e.req = (pg == first) ? "R2" : "R3";
          q.push_back(e);
          off++; cnt++;
        end
      end
    end
    if (!aborted && (good || accept_err)) begin
      e.is_abort = 1'b0; e.req = "R5";
      e.addr = {first, 4'd0}; e.data = st;                  q.push_back(e);
      e.addr = {first, 4'd1}; e.data = step_pg(pg);         q.push_back(e);
      e.addr = {first, 4'd2}; e.data = 8'(cnt);             q.push_back(e);
      e.addr = {first, 4'd3}; e.data = 8'(cnt >> 8);        q.push_back(e);
      ecurr = step_pg(pg);
    end
    frm_start = 1'b1; tick(); frm_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b1; byte_d = seed + 8'(i); tick();
    end
    byte_vld = 1'b0;
    frm_end = 1'b1; frm_good = good; rx_stat = st; tick();
    frm_end = 1'b0; frm_good = 1'b0;
    repeat (8) tick();
    chk(creq, 32'(curr_page), 32'(ecurr));
    chk(creq, 32'(q.size()), 32'd0);
  endtask

  initial begin
    repeat (3) tick();
    chk("R1 reset curr", 32'(curr_page), 32'd0);
    chk("R1 reset outputs", {wr_en, abort}, 32'd0);
    rst_n = 1'b1;
    tick();
    curr_init = 1'b1; tick(); curr_init = 1'b0; tick();
    ecurr = pstart;
    chk("R1 init", 32'(curr_page), 32'(pstart));

    send_frame(5,  1'b1, 8'h01, 8'h10, "R6 short frame");
    send_frame(20, 1'b1, 8'h21, 8'h40, "R6 two pages");
    send_frame(20, 1'b1, 8'h21, 8'h80, "R3 wrap mid frame");
    send_frame(3,  1'b0, 8'h05, 8'hA0, "R7 reject");
    accept_err = 1'b1;
    send_frame(3,  1'b0, 8'h05, 8'hB0, "R8 accept errored");
    accept_err = 1'b0;
    bndry = 8'd5;
    send_frame(20, 1'b1, 8'h01, 8'hC0, "R4 boundary abort");
    bndry = 8'd1;
    send_frame(12, 1'b1, 8'h01, 8'hD0, "R6 exact page fill");
    send_frame(2,  1'b1, 8'h01, 8'hE0, "R6 next pointer wrap");
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule